// File: doc/BRIEF.md
# Control/Status Register Read-Modify-Write Unit

This block is a small bank of 64-bit control and status registers placed at chosen 12-bit addresses. Registers are reached through a single access port that takes a 32-bit system instruction word together with the value of its first source register. Each access is one of three kinds: swap, set-bits or clear-bits. Each kind has two forms. One takes its operand from the source register value. The other takes a 5-bit immediate held in the source-register field of the instruction.

Each access completes in one clock edge. On that edge the addressed register takes its new value, and the response registers capture the value the register held before the edge. The response is therefore visible one cycle after the request, with the prior value ready for the destination register. A write strobe output tells which accesses really changed storage. The set and clear kinds skip the write when their operand is zero, so a set-bits access with a zero operand acts as a pure read. Addresses that match no register read as zero and discard writes. The two function codes that name no access kind get no response at all.

The operation decode is a single `unique case` over the function code. It maps each code to one of four kinds: none, swap, set or clear. There is no multi-cycle state: every request is finished on the edge that follows it.

Top module: `csr_rmw_unit`

## Requirements
- R1: After reset every register holds zero and both `rsp_valid` and `wr_fire` are low.
- R2: The register address comes from instruction bits 31:20. The function code comes from bits 14:12. The 5-bit immediate comes from bits 19:15 and is zero-extended to 64 bits.
- R3: A request with a legal function code, presented while `acc_valid` is high, raises `rsp_valid` on the next cycle. In that same cycle `rsp_old` carries the value the addressed register held before the access. With no request, `rsp_valid` is low on the next cycle.
- R4: Function codes 1 (register operand) and 5 (immediate operand) swap. They always write the operand to a mapped register, even when the operand is zero.
- R5: Function codes 2 (register operand) and 6 (immediate operand) set bits. They write the old value ORed with the operand.
- R6: Function codes 3 (register operand) and 7 (immediate operand) clear bits. They write the old value ANDed with the inverted operand.
- R7: For set-bits and clear-bits accesses with a zero operand, no write occurs: the register keeps its value and `wr_fire` stays low.
- R8: `wr_fire` is high in the response cycle exactly when the access updated a register. It is never high without `rsp_valid`.
- R9: An access to an address that matches no register returns zero and does not write: `wr_fire` is low, and a later read of that address still returns zero.
- R10: Function codes 0 and 4 give no response and no write.
- R11: Accesses on consecutive cycles to the same register are atomic: each one sees the value left by the one before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Request present this cycle |
| acc_insn | input | 32 | Instruction word: address, immediate and function code fields |
| acc_rs1 | input | 64 | Value of the first source register |
| rsp_valid | output | 1 | Response present (one cycle after a legal request) |
| rsp_old | output | 64 | Prior value of the addressed register |
| wr_fire | output | 1 | The access updated a register |

## Verification
The hardest case to reach from the ports is write suppression. Suppression by a zero operand has to be told apart from a write that happens to leave the value unchanged. The stimulus first loads a register with a non-zero pattern. It then issues zero-operand set and clear accesses in both operand forms, followed by a swap with zero. The bench can then see `wr_fire` stay low for the first two and go high for the third, and the next access reveals whether the pattern survived. Requests are also issued back to back on one register and on an unmapped address. This shows that each prior value returned reflects the access just before it.

// File: rtl/csr_rmw_pkg.sv
package csr_rmw_pkg;

    localparam int XLEN_P   = 64;
    localparam int ADDR_W_P = 12;
    localparam int IMM_W_P  = 5;

    // Access kinds after decode of the function code
    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_SWAP = 2'd1,
        KIND_SET  = 2'd2,
        KIND_CLR  = 2'd3
    } csr_kind_e;

    // Instruction field positions (fixed by the instruction encoding)
    localparam int ADDR_LSB  = 20;
    localparam int IMM_LSB   = 15;
    localparam int FUNC_LSB  = 12;

endpackage

// File: rtl/csr_kind_decode.sv
module csr_kind_decode
    import csr_rmw_pkg::*;
(
    input  logic [2:0] func_code,
    output csr_kind_e  kind,
    output logic       use_imm
);

    // bit 2 picks the immediate operand, bits 1:0 pick the kind
    always_comb begin
        use_imm = func_code[2];
        unique case (func_code[1:0])
            2'b01:   kind = KIND_SWAP;
            2'b10:   kind = KIND_SET;
            2'b11:   kind = KIND_CLR;
            default: kind = KIND_NONE;
        endcase
    end

endmodule

// File: rtl/csr_reg_bank.sv
module csr_reg_bank #(
    parameter int                               XLEN      = 64,
    parameter int                               ADDR_W    = 12,
    parameter int                               NUM_REGS  = 4,
    parameter logic [NUM_REGS-1:0][ADDR_W-1:0]  REG_ADDRS = '0,
    parameter logic [XLEN-1:0]                  RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [XLEN-1:0]   wr_data,
    output logic              hit,
    output logic [XLEN-1:0]   rd_data
);

    logic [NUM_REGS-1:0]           match;
    logic [NUM_REGS-1:0][XLEN-1:0] regs;
    logic [NUM_REGS-1:0][XLEN-1:0] masked;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_REGS; gi++) begin : g_reg
            assign match[gi]  = (addr == REG_ADDRS[gi]);
            assign masked[gi] = match[gi] ? regs[gi] : '0;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    regs[gi] <= RESET_VAL;
                end else if (wr_en && match[gi]) begin
                    regs[gi] <= wr_data;
                end
            end
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            rd_data = rd_data | masked[i];
        end
    end

    assign hit = |match;

    // a write always lands: the same address reads back the written data (R11)
    assert_write_lands_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit) |=> (($past(addr) != addr) || (rd_data == $past(wr_data))));

endmodule

// File: rtl/csr_rmw_unit.sv
module csr_rmw_unit
    import csr_rmw_pkg::*;
#(
    parameter int                               XLEN      = 64,
    parameter int                               ADDR_W    = 12,
    parameter int                               IMM_W     = 5,
    parameter int                               NUM_REGS  = 4,
    parameter logic [NUM_REGS-1:0][ADDR_W-1:0]  REG_ADDRS = {12'hFFF, 12'h7C0, 12'h340, 12'h001}
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_valid,
    input  logic [31:0]     acc_insn,
    input  logic [XLEN-1:0] acc_rs1,
    output logic            rsp_valid,
    output logic [XLEN-1:0] rsp_old,
    output logic            wr_fire
);

    localparam int FUNC_W = 3;

    logic [ADDR_W-1:0] f_addr;
    logic [IMM_W-1:0]  f_imm;
    logic [FUNC_W-1:0] f_func;
    csr_kind_e         kind;
    logic              use_imm;
    logic [XLEN-1:0]   operand;
    logic [XLEN-1:0]   old_val;
    logic [XLEN-1:0]   new_val;
    logic              bank_hit;
    logic              legal;
    logic              do_write;

    assign f_addr = acc_insn[ADDR_LSB +: ADDR_W];
    assign f_imm  = acc_insn[IMM_LSB +: IMM_W];
    assign f_func = acc_insn[FUNC_LSB +: FUNC_W];

    csr_kind_decode u_dec (
        .func_code (f_func),
        .kind      (kind),
        .use_imm   (use_imm)
    );

    assign operand = use_imm ? {{(XLEN-IMM_W){1'b0}}, f_imm} : acc_rs1;
    assign legal   = (kind != KIND_NONE);

    always_comb begin
        unique case (kind)
            KIND_SWAP: new_val = operand;
            KIND_SET:  new_val = old_val | operand;
            KIND_CLR:  new_val = old_val & ~operand;
            default:   new_val = old_val;
        endcase
    end

    assign do_write = acc_valid && legal && bank_hit &&
                      ((kind == KIND_SWAP) || (operand != '0));

    csr_reg_bank #(
        .XLEN      (XLEN),
        .ADDR_W    (ADDR_W),
        .NUM_REGS  (NUM_REGS),
        .REG_ADDRS (REG_ADDRS),
        .RESET_VAL ('0)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (f_addr),
        .wr_en   (do_write),
        .wr_data (new_val),
        .hit     (bank_hit),
        .rd_data (old_val)
    );

    // response register: prior value and write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_old   <= '0;
            wr_fire   <= 1'b0;
        end else begin
            rsp_valid <= acc_valid && legal;
            wr_fire   <= do_write;
            if (acc_valid && legal) begin
                rsp_old <= old_val;
            end
        end
    end

    assert_swap_writes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && kind == KIND_SWAP && bank_hit) |=> wr_fire);

    assert_zero_operand_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && (kind == KIND_SET || kind == KIND_CLR) && operand == '0) |=> !wr_fire);

    assert_fire_needs_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |-> rsp_valid);

    assert_unmapped_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && legal && !bank_hit) |=> (!wr_fire && rsp_old == '0));

    assert_no_rsp_illegal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && kind == KIND_NONE) |=> (!rsp_valid && !wr_fire));

    assert_idle_no_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !rsp_valid);

endmodule

// File: tb/csr_rmw_unit_tb_top.sv
`timescale 1ns/1ps
module csr_rmw_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_insn = '0;
    logic [63:0] acc_rs1 = '0;
    logic        rsp_valid;
    logic [63:0] rsp_old;
    logic        wr_fire;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    csr_rmw_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_insn  (acc_insn),
        .acc_rs1   (acc_rs1),
        .rsp_valid (rsp_valid),
        .rsp_old   (rsp_old),
        .wr_fire   (wr_fire)
    );

    // bench-side register model
    localparam logic [11:0] MAP [4] = '{12'h001, 12'h340, 12'h7C0, 12'hFFF};
    logic [63:0] model [4];

    typedef struct {
        logic        valid;
        logic [63:0] old;
        logic        wr;
        string       req;
    } exp_t;
    exp_t sb_q [$];

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp, input string what);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // driver: field layout per R2, kinds per R4..R6, suppression per R7, R9, R10
    task automatic issue(input logic [2:0] f3, input logic [11:0] addr,
                         input logic [4:0] zimm, input logic [63:0] src, input string req);
        exp_t e;
        int idx = -1;
        logic [63:0] opnd, old, nv;
        logic legal, wr;
        @(negedge clk);
        for (int i = 0; i < 4; i++) if (MAP[i] == addr) idx = i;
        old   = (idx >= 0) ? model[idx] : 64'd0;
        opnd  = f3[2] ? {59'd0, zimm} : src;
        legal = (f3[1:0] != 2'b00);
        case (f3[1:0])
            2'b01:   nv = opnd;
            2'b10:   nv = old | opnd;
            2'b11:   nv = old & ~opnd;
            default: nv = old;
        endcase
        wr = legal && (idx >= 0) && ((f3[1:0] == 2'b01) || (opnd != 64'd0));
        if (wr) model[idx] = nv;
        e.valid = legal; e.old = old; e.wr = wr; e.req = req;
        sb_q.push_back(e);
        acc_valid = 1'b1;
        acc_insn  = {addr, zimm, f3, 5'd3, 7'h73};
        acc_rs1   = src;
    endtask

    // monitor: pops one expected item per issued request
    always @(posedge clk) begin
        #1;
        if (sb_q.size() != 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(rsp_valid == e.valid, e.req, {63'd0, rsp_valid}, {63'd0, e.valid}, "rsp_valid");
            if (e.valid) begin
                check(rsp_old == e.old, e.req, rsp_old, e.old, "rsp_old");
                check(wr_fire == e.wr, e.req, {63'd0, wr_fire}, {63'd0, e.wr}, "wr_fire");
            end else begin
                check(wr_fire == 1'b0, e.req, {63'd0, wr_fire}, 64'd0, "wr_fire");
            end
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R1", {63'd0, rsp_valid}, 64'd0, "rsp_valid after reset");
        check(wr_fire == 1'b0,   "R1", {63'd0, wr_fire},   64'd0, "wr_fire after reset");

        // reset contents read through zero-operand set (R1, R7)
        for (int i = 0; i < 4; i++) issue(3'd2, MAP[i], 5'd0, 64'd0, "R1_reset_read");

        issue(3'd1, 12'h340, 5'd0, 64'hA5A5_0000_FFFF_1234, "R4_swap_reg");
        issue(3'd6, 12'h340, 5'h12, 64'hDEAD, "R5_set_imm_R2");
        issue(3'd3, 12'h340, 5'd0, 64'h0000_0000_0000_FFF0, "R6_clear_reg");
        issue(3'd2, 12'h340, 5'd0, 64'd0, "R7_set_reg_zero");
        issue(3'd7, 12'h340, 5'd0, 64'hFFFF, "R7_clear_imm_zero");
        issue(3'd3, 12'h340, 5'd0, 64'd0, "R7_clear_reg_zero");
        issue(3'd6, 12'h340, 5'd0, 64'h1, "R7_set_imm_zero");
        issue(3'd1, 12'h340, 5'd0, 64'd0, "R4_swap_zero");
        issue(3'd2, 12'h340, 5'd0, 64'd0, "R8_read_after_swap_zero");
        issue(3'd5, 12'hFFF, 5'd31, 64'h1234, "R2_swap_imm_max");
        issue(3'd2, 12'h001, 5'd0, 64'h8000_0000_0000_0001, "R5_set_reg");
        issue(3'd6, 12'h001, 5'd4, 64'd0, "R11_back_to_back_set");
        issue(3'd7, 12'h001, 5'd1, 64'd0, "R11_back_to_back_clear");
        issue(3'd1, 12'h7C0, 5'd0, 64'hFFFF_FFFF_FFFF_FFFF, "R4_swap_ones");
        issue(3'd5, 12'h7C0, 5'd7, 64'd0, "R11_swap_after_swap");
        issue(3'd1, 12'h123, 5'd0, 64'h5555, "R9_unmapped_swap");
        issue(3'd6, 12'h123, 5'd3, 64'd0, "R9_unmapped_set");
        issue(3'd2, 12'h123, 5'd0, 64'd0, "R9_unmapped_readback");
        issue(3'd0, 12'h340, 5'd9, 64'h77, "R10_func0");
        issue(3'd4, 12'h001, 5'd9, 64'h77, "R10_func4");
        issue(3'd2, 12'h001, 5'd0, 64'd0, "R10_readback");
        issue(3'd2, 12'hFFF, 5'd0, 64'd0, "R3_final_read");
        @(negedge clk);
        acc_valid = 1'b0;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R3", {63'd0, rsp_valid}, 64'd0, "rsp_valid idle");
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule